// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events for one processor core. It has a dedicated 32-bit cycle counter and a parameterised number of 32-bit event counters. Each event counter is given an event number and counts single-cycle pulses from a vector of event inputs. Software reaches the unit through a single-cycle register write port and a combinational read port, both addressed by register number. Each event counter is reached through a select register. Enables and interrupt enables are changed through separate set and clear registers, so software can modify one counter without a read-modify-write.

A two-bit privilege input, giving the current exception level, is compared with per-counter filter bits on every cycle. When a counter wraps from all-ones to zero it sets a sticky overflow flag. One combined interrupt line stays high while any flagged counter also has its interrupt enabled. The cycle counter can be slowed to one step every 64 counting cycles.

Register addresses are: 0 control, 1 select, 2 event type of the selected counter, 3 value of the selected counter, 4 cycle counter value, 5/6 counter-enable set/clear, 7/8 interrupt-enable set/clear, 9 overflow status, 10 software increment.

Top module: `perf_monitor`

## Requirements
- R1: After reset, all counters, types, enables, flags, select and control bits are zero and the interrupt is low. A read of the control register returns the number of event counters in bits [15:11].
- R2: Control bit 0 is the global enable. While it is 0, no counter changes except by a register write.
- R3: Writing control with bit 1 set clears every event counter. Writing it with bit 2 set clears the cycle counter and its divide prescaler. Bits 1 and 2 always read back as 0. Bits 0, 3, 4 and 5 are stored.
- R4: When control bit 3 is set, the cycle counter advances once per 64 counting cycles instead of on every counting cycle.
- R5: A select value n below the counter count routes the type and value registers (addresses 2 and 3) to event counter n. A select value of 31 routes them to the cycle counter's filter and value. Any other select value reads 0 and ignores writes.
- R6: An event-type write keeps only the bits under 0xC80003FF. A cycle-filter write keeps only the bits under 0xC8000000.
- R7: Privilege input 0 counts unless type bit 30 is set. Input 1 counts unless bit 31 is set. Input 2 counts only if bit 27 is set. Input 3 never counts.
- R8: Event number 0x11 counts every cycle. Event number 0x00 counts writes to address 10 that have bit n set, for counter n. Other numbers below the input width count event input pulses with that index. Larger numbers never count.
- R9: In the enable and interrupt-enable masks, bit n is event counter n and bit 31 is the cycle counter. Writing 1 to a set register sets the bit and writing 1 to a clear register clears it. Both registers read the mask, and bits for counters that do not exist read 0.
- R10: A wrap from 0xFFFFFFFF to 0 sets that counter's overflow bit (same bit positions as R9). Writing 1 clears the bit, writing 0 leaves it unchanged, and a new wrap in the same cycle wins over the clear.
- R11: The interrupt output is high exactly while some overflow bit and its interrupt-enable bit are both set.
- R12: A write to a counter value takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register number for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| event_pulse | input | NUM_EVENTS | One single-cycle pulse line per event number |
| priv_lvl | input | 2 | Current exception level, 0 to 3 |
| ovf_irq | output | 1 | Combined overflow interrupt |

## Verification
A wrong filter decision or a wrong event-index decode shows up as a wrong counter value on the first read after the stimulus. A stale enable or prescaler state shows up as a cycle count that drifts away from the reference within one divide period. Overflow-flag and interrupt-enable state drive the interrupt pin directly, so a fault there shows on the pin in the clock cycle right after the wrap or the write. That pin is compared against the reference on every cycle.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

    localparam int REG_AW  = 4;
    localparam int SEL_W   = 5;
    localparam int CYC_BIT = 31;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL      = 4'd0,
        A_SEL       = 4'd1,
        A_EVTYPE    = 4'd2,
        A_EVCNT     = 4'd3,
        A_CYCCNT    = 4'd4,
        A_CNTEN_SET = 4'd5,
        A_CNTEN_CLR = 4'd6,
        A_INTEN_SET = 4'd7,
        A_INTEN_CLR = 4'd8,
        A_OVF       = 4'd9,
        A_SWINC     = 4'd10
    } reg_addr_e;

    // control bit positions
    localparam int CTL_EN      = 0;
    localparam int CTL_RST_EV  = 1;
    localparam int CTL_RST_CYC = 2;
    localparam int CTL_DIV     = 3;
    localparam logic [5:0] CTRL_KEEP = 6'b111001;

    // filter bit positions in a type word
    localparam int FLT_NO_EL1  = 31;
    localparam int FLT_NO_EL0  = 30;
    localparam int FLT_YES_EL2 = 27;

    localparam logic [31:0] TYPE_KEEP = 32'hC800_03FF;
    localparam logic [31:0] FILT_KEEP = 32'hC800_0000;
    localparam logic [9:0]  EV_SWINC  = 10'h000;
    localparam logic [9:0]  EV_CYCLES = 10'h011;

    function automatic logic [31:0] impl_mask(input int n);
        return 32'h8000_0000 | ((32'd1 << n) - 32'd1);
    endfunction

    function automatic logic priv_pass(input logic no_el1, input logic no_el0,
                                       input logic yes_el2, input logic [1:0] el);
        logic ok;
        case (el)
            2'd0:    ok = !no_el0;
            2'd1:    ok = !no_el1;
            2'd2:    ok = yes_el2;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pm_event_counter.sv
module pm_event_counter
    import perf_mon_pkg::*;
#(
    parameter int NUM_EVENTS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  count_ok,
    input  logic [1:0]            priv_lvl,
    input  logic [NUM_EVENTS-1:0] ev_pulse,
    input  logic                  swinc,
    input  logic                  clr_all,
    input  logic                  type_we,
    input  logic                  val_we,
    input  logic [31:0]           wdata,
    output logic [31:0]           type_q,
    output logic [31:0]           val_q,
    output logic                  ovf_set
);

    localparam int IDXW = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

    typedef struct packed {
        logic [31:0] evtype;
        logic [31:0] cnt;
    } evc_st_t;

    evc_st_t st_d, st_q;
    logic    hit;
    logic    inc;
    logic [9:0] evt;

    always_comb begin
        st_d = st_q;
        evt  = st_q.evtype[9:0];
        if (evt == EV_CYCLES) begin
            hit = 1'b1;
        end else if (evt == EV_SWINC) begin
            hit = swinc;
        end else if (evt < 10'(NUM_EVENTS)) begin
            hit = ev_pulse[evt[IDXW-1:0]];
        end else begin
            hit = 1'b0;
        end
        inc = count_ok && hit &&
              priv_pass(st_q.evtype[FLT_NO_EL1], st_q.evtype[FLT_NO_EL0],
                        st_q.evtype[FLT_YES_EL2], priv_lvl);
        ovf_set = 1'b0;
        if (val_we) begin
            st_d.cnt = wdata;
        end else if (clr_all) begin
            st_d.cnt = '0;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 32'd1;
            ovf_set  = (st_q.cnt == 32'hFFFF_FFFF);
        end
        if (type_we) begin
            st_d.evtype = wdata & TYPE_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign type_q = st_q.evtype;
    assign val_q  = st_q.cnt;

endmodule

// File: rtl/pm_cycle_counter.sv
module pm_cycle_counter
    import perf_mon_pkg::*;
#(
    parameter int DIV_LOG2 = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        count_ok,
    input  logic [1:0]  priv_lvl,
    input  logic        div_en,
    input  logic        clr,
    input  logic        filt_we,
    input  logic        val_we,
    input  logic [31:0] wdata,
    output logic [31:0] filt_q,
    output logic [31:0] val_q,
    output logic        ovf_set
);

    typedef struct packed {
        logic [31:0]         filt;
        logic [31:0]         cnt;
        logic [DIV_LOG2-1:0] presc;
    } cyc_st_t;

    cyc_st_t st_d, st_q;
    logic    tick;
    logic    step;

    always_comb begin
        st_d    = st_q;
        tick    = count_ok &&
                  priv_pass(st_q.filt[FLT_NO_EL1], st_q.filt[FLT_NO_EL0],
                            st_q.filt[FLT_YES_EL2], priv_lvl);
        step    = tick && (!div_en || (&st_q.presc));
        ovf_set = 1'b0;
        if (clr) begin
            st_d.cnt   = '0;
            st_d.presc = '0;
        end else begin
            if (tick) begin
                st_d.presc = st_q.presc + 1'b1;
            end
            if (val_we) begin
                st_d.cnt = wdata;
            end else if (step) begin
                st_d.cnt = st_q.cnt + 32'd1;
                ovf_set  = (st_q.cnt == 32'hFFFF_FFFF);
            end
        end
        if (filt_we) begin
            st_d.filt = wdata & FILT_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_q = st_q.filt;
    assign val_q  = st_q.cnt;

endmodule

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
    import perf_mon_pkg::*;
#(
    parameter int NUM_CNT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             sel_we,
    input  logic             cen_set_we,
    input  logic             cen_clr_we,
    input  logic             ien_set_we,
    input  logic             ien_clr_we,
    input  logic             ovf_clr_we,
    input  logic [31:0]      wdata,
    input  logic [31:0]      ovf_set,
    output logic [5:0]       ctrl_q,
    output logic [SEL_W-1:0] sel_q,
    output logic [31:0]      cnten_q,
    output logic [31:0]      inten_q,
    output logic [31:0]      ovf_q,
    output logic             irq
);

    localparam logic [31:0] IMPL = impl_mask(NUM_CNT);

    typedef struct packed {
        logic [5:0]       ctrl;
        logic [SEL_W-1:0] sel;
        logic [31:0]      cen;
        logic [31:0]      ien;
        logic [31:0]      ovf;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we)    st_d.ctrl = wdata[5:0] & CTRL_KEEP;
        if (sel_we)     st_d.sel  = wdata[SEL_W-1:0];
        if (cen_set_we) st_d.cen  = st_q.cen | (wdata & IMPL);
        if (cen_clr_we) st_d.cen  = st_q.cen & ~(wdata & IMPL);
        if (ien_set_we) st_d.ien  = st_q.ien | (wdata & IMPL);
        if (ien_clr_we) st_d.ien  = st_q.ien & ~(wdata & IMPL);
        if (ovf_clr_we) st_d.ovf  = st_q.ovf & ~wdata;
        st_d.ovf = st_d.ovf | (ovf_set & IMPL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q  = st_q.ctrl;
    assign sel_q   = st_q.sel;
    assign cnten_q = st_q.cen;
    assign inten_q = st_q.ien;
    assign ovf_q   = st_q.ovf;
    assign irq     = |(st_q.ovf & st_q.ien);

endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import perf_mon_pkg::*;
#(
    parameter int NUM_EVT_CNT = 6,
    parameter int NUM_EVENTS  = 32,
    parameter int DIV_LOG2    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NUM_EVENTS-1:0] event_pulse,
    input  logic [1:0]            priv_lvl,
    output logic                  ovf_irq
);

    localparam logic [SEL_W-1:0] CYC_SEL = SEL_W'(CYC_BIT);

    logic [5:0]             ctrl_q;
    logic [SEL_W-1:0]       sel_q;
    logic [31:0]            cnten_q;
    logic [31:0]            inten_q;
    logic [31:0]            ovf_q;
    logic [31:0]            ovf_set;
    logic [31:0]            ev_type [NUM_EVT_CNT];
    logic [31:0]            ev_val  [NUM_EVT_CNT];
    logic [NUM_EVT_CNT-1:0] ev_ovf;
    logic [31:0]            cyc_filt;
    logic [31:0]            cyc_val;
    logic                   cyc_ovf;
    logic                   sel_is_cyc;
    logic [31:0]            sel_type;
    logic [31:0]            sel_val;
    logic [31:0]            ctrl_rd;

    logic wr_ctrl, wr_sel, wr_evtype, wr_evcnt, wr_cycval;
    logic wr_cset, wr_cclr, wr_iset, wr_iclr, wr_ovf, wr_swinc;

    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_sel    = reg_wr && (reg_addr == A_SEL);
    assign wr_evtype = reg_wr && (reg_addr == A_EVTYPE);
    assign wr_evcnt  = reg_wr && (reg_addr == A_EVCNT);
    assign wr_cycval = reg_wr && (reg_addr == A_CYCCNT);
    assign wr_cset   = reg_wr && (reg_addr == A_CNTEN_SET);
    assign wr_cclr   = reg_wr && (reg_addr == A_CNTEN_CLR);
    assign wr_iset   = reg_wr && (reg_addr == A_INTEN_SET);
    assign wr_iclr   = reg_wr && (reg_addr == A_INTEN_CLR);
    assign wr_ovf    = reg_wr && (reg_addr == A_OVF);
    assign wr_swinc  = reg_wr && (reg_addr == A_SWINC);
    assign sel_is_cyc = (sel_q == CYC_SEL);

    pm_ctrl_regs #(.NUM_CNT(NUM_EVT_CNT)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (wr_ctrl),
        .sel_we     (wr_sel),
        .cen_set_we (wr_cset),
        .cen_clr_we (wr_cclr),
        .ien_set_we (wr_iset),
        .ien_clr_we (wr_iclr),
        .ovf_clr_we (wr_ovf),
        .wdata      (reg_wdata),
        .ovf_set    (ovf_set),
        .ctrl_q     (ctrl_q),
        .sel_q      (sel_q),
        .cnten_q    (cnten_q),
        .inten_q    (inten_q),
        .ovf_q      (ovf_q),
        .irq        (ovf_irq)
    );

    for (genvar g = 0; g < NUM_EVT_CNT; g++) begin : g_evc
        pm_event_counter #(.NUM_EVENTS(NUM_EVENTS)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_ok (ctrl_q[CTL_EN] && cnten_q[g]),
            .priv_lvl (priv_lvl),
            .ev_pulse (event_pulse),
            .swinc    (wr_swinc && reg_wdata[g]),
            .clr_all  (wr_ctrl && reg_wdata[CTL_RST_EV]),
            .type_we  (wr_evtype && (sel_q == SEL_W'(g))),
            .val_we   (wr_evcnt && (sel_q == SEL_W'(g))),
            .wdata    (reg_wdata),
            .type_q   (ev_type[g]),
            .val_q    (ev_val[g]),
            .ovf_set  (ev_ovf[g])
        );
    end

    pm_cycle_counter #(.DIV_LOG2(DIV_LOG2)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_ok (ctrl_q[CTL_EN] && cnten_q[CYC_BIT]),
        .priv_lvl (priv_lvl),
        .div_en   (ctrl_q[CTL_DIV]),
        .clr      (wr_ctrl && reg_wdata[CTL_RST_CYC]),
        .filt_we  (wr_evtype && sel_is_cyc),
        .val_we   (wr_cycval || (wr_evcnt && sel_is_cyc)),
        .wdata    (reg_wdata),
        .filt_q   (cyc_filt),
        .val_q    (cyc_val),
        .ovf_set  (cyc_ovf)
    );

    always_comb begin
        ovf_set                  = '0;
        ovf_set[NUM_EVT_CNT-1:0] = ev_ovf;
        ovf_set[CYC_BIT]         = cyc_ovf;
    end

    always_comb begin
        sel_type = '0;
        sel_val  = '0;
        if (sel_is_cyc) begin
            sel_type = cyc_filt;
            sel_val  = cyc_val;
        end else begin
            for (int i = 0; i < NUM_EVT_CNT; i++) begin
                if (sel_q == SEL_W'(i)) begin
                    sel_type = ev_type[i];
                    sel_val  = ev_val[i];
                end
            end
        end
    end

    always_comb begin
        ctrl_rd        = '0;
        ctrl_rd[5:0]   = ctrl_q;
        ctrl_rd[15:11] = 5'(NUM_EVT_CNT);
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            A_CTRL:      reg_rdata = ctrl_rd;
            A_SEL:       reg_rdata = {{(32-SEL_W){1'b0}}, sel_q};
            A_EVTYPE:    reg_rdata = sel_type;
            A_EVCNT:     reg_rdata = sel_val;
            A_CYCCNT:    reg_rdata = cyc_val;
            A_CNTEN_SET,
            A_CNTEN_CLR: reg_rdata = cnten_q;
            A_INTEN_SET,
            A_INTEN_CLR: reg_rdata = inten_q;
            A_OVF:       reg_rdata = ovf_q;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pm_checker.sv
module pm_checker
    import perf_mon_pkg::*;
#(
    parameter int NUM_CNT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic [5:0]       ctrl_q,
    input logic [SEL_W-1:0] sel_q,
    input logic [31:0]      cnten_q,
    input logic [31:0]      ovf_q,
    input logic [31:0]      cyc_val,
    input logic             ovf_irq
);

    localparam logic [31:0] IMPL = impl_mask(NUM_CNT);

    logic wr_cyc;
    logic wr_cclr;
    assign wr_cyc  = reg_wr && ((reg_addr == A_CYCCNT) ||
                               ((reg_addr == A_EVCNT) && (sel_q == SEL_W'(CYC_BIT))));
    assign wr_cclr = reg_wr && (reg_addr == A_CTRL) && reg_wdata[CTL_RST_CYC];

    p_count_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> (reg_rdata[15:11] == 5'(NUM_CNT)));

    p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTL_EN] && !wr_cyc && !wr_cclr) |=> (cyc_val == $past(cyc_val)));

    p_div_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTL_DIV] && !wr_cyc && !wr_cclr) |=> ((cyc_val - $past(cyc_val)) <= 32'd1));

    p_set_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_CNTEN_SET)) |=>
        ((cnten_q & $past(reg_wdata & IMPL)) == $past(reg_wdata & IMPL)));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == A_OVF)) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_INTEN_SET) && ((reg_wdata & ovf_q & IMPL) != 32'd0))
        |=> ovf_irq);

endmodule

bind perf_monitor pm_checker #(.NUM_CNT(NUM_EVT_CNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctrl_q    (ctrl_q),
    .sel_q     (sel_q),
    .cnten_q   (cnten_q),
    .ovf_q     (ovf_q),
    .cyc_val   (cyc_val),
    .ovf_irq   (ovf_irq)
);

// File: tb/perf_monitor_tb.sv
`timescale 1ns/1ps
module perf_monitor_tb;
    import perf_mon_pkg::*;

    localparam int N  = 4;
    localparam int NE = 32;
    localparam logic [31:0] IMPL = 32'h8000_000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [NE-1:0] event_pulse = '0;
    logic [1:0]  priv_lvl = 2'd0;
    logic        ovf_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    perf_monitor #(.NUM_EVT_CNT(N), .NUM_EVENTS(NE)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_pulse(event_pulse),
        .priv_lvl(priv_lvl), .ovf_irq(ovf_irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_type [N];
    logic [31:0] m_cnt  [N];
    logic [31:0] m_cfilt, m_cyc, m_cnten, m_inten, m_ovf;
    logic [5:0]  m_ctrl;
    logic [4:0]  m_sel;
    int          m_presc;

    function automatic bit m_pass(input logic [31:0] t, input logic [1:0] el);
        if (el == 2'd0) return !t[30];
        if (el == 2'd1) return !t[31];
        if (el == 2'd2) return t[27];
        return 0;
    endfunction

    always @(posedge clk) begin
        logic [31:0] set_v;
        bit wctl, hit, inc, tick, step, wcyc;
        int evn;
        set_v = 0;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_type[i] = 0; m_cnt[i] = 0; end
            m_cfilt = 0; m_cyc = 0; m_cnten = 0; m_inten = 0; m_ovf = 0;
            m_ctrl = 0; m_sel = 0; m_presc = 0;
        end else begin
            wctl = reg_wr && reg_addr == A_CTRL;
            for (int i = 0; i < N; i++) begin
                evn = int'(m_type[i][9:0]);
                if (evn == 17) hit = 1;
                else if (evn == 0) hit = reg_wr && reg_addr == A_SWINC && reg_wdata[i];
                else if (evn < NE) hit = event_pulse[evn];
                else hit = 0;
                inc = m_ctrl[0] && m_cnten[i] && m_pass(m_type[i], priv_lvl) && hit;
                if (reg_wr && reg_addr == A_EVCNT && m_sel == 5'(i)) m_cnt[i] = reg_wdata;
                else if (wctl && reg_wdata[1]) m_cnt[i] = 0;
                else if (inc) begin
                    if (m_cnt[i] == 32'hFFFF_FFFF) set_v[i] = 1;
                    m_cnt[i] = m_cnt[i] + 1;
                end
                if (reg_wr && reg_addr == A_EVTYPE && m_sel == 5'(i))
                    m_type[i] = reg_wdata & 32'hC800_03FF;
            end
            tick = m_ctrl[0] && m_cnten[31] && m_pass(m_cfilt, priv_lvl);
            wcyc = reg_wr && (reg_addr == A_CYCCNT || (reg_addr == A_EVCNT && m_sel == 5'd31));
            if (wctl && reg_wdata[2]) begin
                m_cyc = 0; m_presc = 0;
            end else begin
                step = tick && (!m_ctrl[3] || m_presc == 63);
                if (tick) m_presc = (m_presc + 1) % 64;
                if (wcyc) m_cyc = reg_wdata;
                else if (step) begin
                    if (m_cyc == 32'hFFFF_FFFF) set_v[31] = 1;
                    m_cyc = m_cyc + 1;
                end
            end
            if (reg_wr && reg_addr == A_EVTYPE && m_sel == 5'd31) m_cfilt = reg_wdata & 32'hC800_0000;
            if (wctl) m_ctrl = reg_wdata[5:0] & 6'b111001;
            if (reg_wr && reg_addr == A_SEL) m_sel = reg_wdata[4:0];
            if (reg_wr && reg_addr == A_CNTEN_SET) m_cnten = m_cnten | (reg_wdata & IMPL);
            if (reg_wr && reg_addr == A_CNTEN_CLR) m_cnten = m_cnten & ~(reg_wdata & IMPL);
            if (reg_wr && reg_addr == A_INTEN_SET) m_inten = m_inten | (reg_wdata & IMPL);
            if (reg_wr && reg_addr == A_INTEN_CLR) m_inten = m_inten & ~(reg_wdata & IMPL);
            if (reg_wr && reg_addr == A_OVF) m_ovf = m_ovf & ~reg_wdata;
            m_ovf = m_ovf | set_v;
        end
    end

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return {16'd0, 5'(N), 5'd0, m_ctrl};
            4'd1: return {27'd0, m_sel};
            4'd2: return (m_sel == 5'd31) ? m_cfilt : (m_sel < 5'(N)) ? m_type[m_sel] : 32'd0;
            4'd3: return (m_sel == 5'd31) ? m_cyc : (m_sel < 5'(N)) ? m_cnt[m_sel] : 32'd0;
            4'd4: return m_cyc;
            4'd5, 4'd6: return m_cnten;
            4'd7, 4'd8: return m_inten;
            4'd9: return m_ovf;
            default: return 32'd0;
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // interrupt pin against the model on every clock (R11)
    always @(negedge clk) begin
        if (rst_n && !done) check("R11 irq per cycle", {31'd0, ovf_irq}, {31'd0, |(m_ovf & m_inten)});
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
        check(tag, v, model_read(a));
    endtask

    task automatic pulse(input int ev, input int n);
        for (int k = 0; k < n; k++) begin
            event_pulse[ev] = 1'b1;
            @(negedge clk);
            event_pulse[ev] = 1'b0;
        end
    endtask

    task automatic summary();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog (R1..) actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, "R1 ctrl", v);       check("R1 ctrl literal", v, 32'h0000_2000);
        rd(A_CNTEN_SET, "R1 cnten", v); check("R1 cnten zero", v, 32'd0);
        rd(A_OVF, "R1 ovf", v);
        rd(A_CYCCNT, "R1 cyc", v);
        check("R1 irq low", {31'd0, ovf_irq}, 32'd0);

        // R8: event number routes event input
        wr(A_SEL, 0); wr(A_EVTYPE, 32'h3); wr(A_CNTEN_SET, 32'h1); wr(A_CTRL, 32'h1);
        pulse(3, 5);
        rd(A_EVCNT, "R8 event pulse count", v); check("R8 five pulses", v, 32'd5);

        // R2: global enable off freezes
        wr(A_CTRL, 0); pulse(3, 3);
        rd(A_EVCNT, "R2 frozen", v); check("R2 frozen literal", v, 32'd5);
        wr(A_CTRL, 32'h1);

        // R6: type mask
        wr(A_SEL, 1); wr(A_EVTYPE, 32'hFFFF_FFFF);
        rd(A_EVTYPE, "R6 type mask", v); check("R6 mask literal", v, 32'hC800_03FF);

        // R7: privilege filter
        wr(A_EVTYPE, 32'h4000_0005); wr(A_CNTEN_SET, 32'h2);
        priv_lvl = 2'd0; pulse(5, 4);
        rd(A_EVCNT, "R7 EL0 excluded", v); check("R7 EL0 literal", v, 32'd0);
        priv_lvl = 2'd1; pulse(5, 4);
        rd(A_EVCNT, "R7 EL1 counts", v); check("R7 EL1 literal", v, 32'd4);
        priv_lvl = 2'd2; pulse(5, 2);
        rd(A_EVCNT, "R7 EL2 off", v); check("R7 EL2 off literal", v, 32'd4);
        wr(A_EVTYPE, 32'h0800_0005); pulse(5, 2);
        rd(A_EVCNT, "R7 EL2 on", v); check("R7 EL2 on literal", v, 32'd6);
        priv_lvl = 2'd3; pulse(5, 2);
        rd(A_EVCNT, "R7 EL3 never", v); check("R7 EL3 literal", v, 32'd6);
        priv_lvl = 2'd0;

        // R12: write beats increment
        event_pulse[5] = 1'b1; wr(A_EVCNT, 32'd100); event_pulse[5] = 1'b0;
        rd(A_EVCNT, "R12 write priority", v); check("R12 literal", v, 32'd100);

        // R8: software increment
        wr(A_SEL, 3); wr(A_CNTEN_SET, 32'h8);
        wr(A_SWINC, 32'h8); wr(A_SWINC, 32'h8); wr(A_SWINC, 32'h9);
        rd(A_EVCNT, "R8 swinc", v); check("R8 swinc literal", v, 32'd3);
        wr(A_SEL, 0); rd(A_EVCNT, "R8 swinc ignored by non-sw counter", v);

        // R10/R11: overflow on cycle event
        wr(A_SEL, 2); wr(A_EVCNT, 32'hFFFF_FFFD); wr(A_EVTYPE, 32'h11);
        wr(A_INTEN_SET, 32'h4); wr(A_CNTEN_SET, 32'h4);
        repeat (5) @(negedge clk);
        rd(A_OVF, "R10 wrap flag", v); check("R10 flag literal", v & 32'h4, 32'h4);
        check("R11 irq high", {31'd0, ovf_irq}, 32'd1);
        wr(A_OVF, 32'h0);
        rd(A_OVF, "R10 zero write keeps", v); check("R10 keep literal", v & 32'h4, 32'h4);
        wr(A_OVF, 32'h4);
        rd(A_OVF, "R10 w1c", v); check("R10 cleared literal", v & 32'h4, 32'h0);
        check("R11 irq low", {31'd0, ovf_irq}, 32'd0);
        wr(A_EVCNT, 32'hFFFF_FFFF); @(negedge clk);
        wr(A_INTEN_CLR, 32'h4);
        rd(A_OVF, "R11 flag with irq off", v);
        check("R11 masked", {31'd0, ovf_irq}, 32'd0);
        wr(A_INTEN_SET, 32'h4);
        check("R11 unmasked", {31'd0, ovf_irq}, 32'd1);
        wr(A_OVF, 32'h4);

        // R9: set/clear masks
        wr(A_CNTEN_SET, 32'hFFFF_FFFF);
        rd(A_CNTEN_CLR, "R9 impl bits", v); check("R9 impl literal", v, 32'h8000_000F);
        wr(A_CNTEN_CLR, 32'h7FFF_FFF0);
        rd(A_CNTEN_SET, "R9 clr unimpl", v);
        wr(A_CNTEN_CLR, 32'h4);
        rd(A_EVCNT, "R9 stopped a", v);
        repeat (4) @(negedge clk);
        rd(A_EVCNT, "R9 stopped b", v2); check("R9 held literal", v2, v);
        rd(A_INTEN_CLR, "R9 inten read", v);

        // R5: select routing
        wr(A_SEL, 5);
        rd(A_EVTYPE, "R5 out of range type", v); check("R5 zero literal", v, 32'd0);
        wr(A_EVCNT, 32'd123); wr(A_EVTYPE, 32'h7);
        for (int i = 0; i < N; i++) begin
            wr(A_SEL, 32'(i));
            rd(A_EVCNT, "R5 untouched value", v);
            rd(A_EVTYPE, "R5 untouched type", v);
        end
        wr(A_SEL, 31); wr(A_EVTYPE, 32'hFFFF_FFFF);
        rd(A_EVTYPE, "R6 cycle filter mask", v); check("R6 filter literal", v, 32'hC800_0000);
        wr(A_EVTYPE, 32'h0);
        rd(A_EVCNT, "R5 sel 31 reads cycle", v);

        // R4: divide-by-64
        wr(A_CTRL, 32'h5);
        repeat (10) @(negedge clk);
        rd(A_CYCCNT, "R4 full rate", v);
        wr(A_CTRL, 32'hD);
        repeat (200) @(negedge clk);
        rd(A_CYCCNT, "R4 divided", v);
        check("R4 divided range", {31'd0, (v >= 2 && v <= 4)}, 32'd1);

        // R3: reset actions
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, "R3 ctrl readback", v); check("R3 readback literal", v, 32'h0000_2001);
        for (int i = 0; i < N; i++) begin
            wr(A_SEL, 32'(i));
            rd(A_EVCNT, "R3 cleared", v);
        end
        wr(A_SEL, 0); rd(A_EVCNT, "R3 counter0", v); check("R3 zero literal", v, 32'd0);
        wr(A_CTRL, 32'h5);
        rd(A_CYCCNT, "R3 cycle cleared", v);

        // R2: cycle counter frozen when disabled
        wr(A_CTRL, 32'h0);
        rd(A_CYCCNT, "R2 cyc a", v);
        repeat (5) @(negedge clk);
        rd(A_CYCCNT, "R2 cyc b", v2); check("R2 cyc held", v2, v);

        summary();
    end

endmodule